// File: doc/BRIEF.md
# Delay-Binned Spike Stimulus Accumulator

This block holds, for each of a small set of neurons, a ring of stimulus accumulators indexed by future time. When an input spike arrives it carries a target neuron, an axonal delay in ticks and a signed synaptic weight. The block adds the weight into the slot that lies that many ticks ahead of the neuron's present time. The neuron is not updated when the spike arrives. Spikes that arrive out of order therefore land in the correct future slot without any queue.

A simulation tick starts a sweep that visits the neurons in ascending index, one per clock. For each neuron it hands the slot for the next time step to a downstream neuron-update stage and clears that slot so that it can be reused one full ring later. The shared time pointer moves forward only after every neuron has been served. A neuron that the sweep has already served is treated as living in the new time step. A spike that targets the slot being read in that very clock is added into the value handed out.

Top module: `spk_bin_acc`

## Requirements
- R1: After reset, `busy`, `stim_valid` and `delay_err` are low and every slot of every neuron reads as zero.
- R2: A spike with delay d (1 to NUM_BINS-1, 4-bit field for 16 slots) for a neuron whose present time is t is handed out on the d-th sweep that serves that neuron after the spike is accepted.
- R3: Several spikes aimed at the same neuron and slot are summed.
- R4: Summation saturates at +32767 and -32768 and does not wrap.
- R5: A tick taken while idle raises `busy` on the next cycle for exactly NUM_NEURONS cycles. `stim_valid` is high one cycle later than `busy`, also for NUM_NEURONS cycles, and `stim_nid` counts from 0 upward.
- R6: A tick that is high while `busy` is high is ignored and does not start or extend a sweep.
- R7: A slot is cleared when it is handed out, so a later pass over the same slot with no new spikes yields zero.
- R8: A spike with delay 0 is dropped, leaves every slot unchanged and raises `delay_err` for one cycle on the next clock. A legal spike never raises it.
- R9: A spike accepted in the same cycle that its neuron's next-step slot is being read, and which targets that slot (delay 1, neuron not yet served), is included in the value handed out.
- R10: During a sweep, a spike for a neuron already served in that sweep counts its delay from the new time step. A spike for a neuron not yet served counts from the old time step.
- R11: Weights are two's complement, so a negative weight lowers the stored sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spike_valid | input | 1 | Spike event present this cycle |
| spike_nid | input | NID_W | Target neuron index |
| spike_delay | input | BIN_W | Axonal delay in ticks, 0 is illegal |
| spike_weight | input | 16 | Signed synaptic weight |
| tick | input | 1 | Simulation time step request, taken only while idle |
| busy | output | 1 | Sweep in progress; a tick is ignored |
| stim_valid | output | 1 | Stimulus word valid for the update stage |
| stim_nid | output | NID_W | Neuron the stimulus belongs to |
| stim_out | output | 16 | Accumulated signed stimulus |
| delay_err | output | 1 | One-cycle pulse for a rejected zero-delay spike |

## Verification
The spike write and the sweep read-and-clear can fall in the same cycle. The bench provokes this by issuing spikes on the cycles right after a tick. The first spike is a delay-1 spike for neuron 0 while neuron 0 is being read, which must appear in the emitted word. The next is a spike for neuron 0 after it has been served, which must arrive two sweeps later. The last is a delay-1 spike for neuron 3 before it is served, which must appear in that same sweep. A behavioural reference model keeps absolute time per neuron and checks every output on every clock.

// File: rtl/spk_bin_pkg.sv
// Shared constants and saturating arithmetic for the spike slot accumulator.
// Assumes stimulus and weight share one signed fixed-point width.
package spk_bin_pkg;
    parameter int STIM_W = 16;

    // Signed add clamped to the representable range.
    function automatic logic signed [STIM_W-1:0] sat_add(
        input logic signed [STIM_W-1:0] a,
        input logic signed [STIM_W-1:0] b
    );
        logic signed [STIM_W:0] s;
        s = {a[STIM_W-1], a} + {b[STIM_W-1], b};
        if (s[STIM_W] != s[STIM_W-1])
            sat_add = s[STIM_W] ? {1'b1, {(STIM_W-1){1'b0}}} : {1'b0, {(STIM_W-1){1'b1}}};
        else
            sat_add = s[STIM_W-1:0];
    endfunction
endpackage

// File: rtl/spk_bin_sweep.sv
// Sweep sequencer: on an accepted tick visits every neuron once, one per clock,
// then advances the shared time pointer. Assumes NUM_NEURONS >= 2.
module spk_bin_sweep #(
    parameter int NUM_NEURONS = 4,
    parameter int NUM_BINS    = 16,
    localparam int NID_W      = $clog2(NUM_NEURONS),
    localparam int BIN_W      = $clog2(NUM_BINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic             busy,
    output logic [NID_W-1:0] rd_idx,
    output logic [BIN_W-1:0] now_ptr
);
    localparam logic [NID_W-1:0] LAST_IDX = NID_W'(NUM_NEURONS - 1);

    // Sweep state: busy flag, neuron cursor and time pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            rd_idx  <= '0;
            now_ptr <= '0;
        end else if (busy) begin
            if (rd_idx == LAST_IDX) begin
                busy    <= 1'b0;
                rd_idx  <= '0;
                now_ptr <= now_ptr + 1'b1;
            end else begin
                rd_idx <= rd_idx + 1'b1;
            end
        end else if (tick) begin
            busy   <= 1'b1;
            rd_idx <= '0;
        end
    end
endmodule

// File: rtl/spk_bin_addr.sv
// Slot address logic: computes the slot a spike lands in and the slot being read,
// and flags the same-cycle collision. Assumes NUM_BINS is a power of two.
module spk_bin_addr #(
    parameter int NUM_NEURONS = 4,
    parameter int NUM_BINS    = 16,
    localparam int NID_W      = $clog2(NUM_NEURONS),
    localparam int BIN_W      = $clog2(NUM_BINS)
) (
    input  logic             spike_valid,
    input  logic [NID_W-1:0] spike_nid,
    input  logic [BIN_W-1:0] spike_delay,
    input  logic             busy,
    input  logic [NID_W-1:0] rd_idx,
    input  logic [BIN_W-1:0] now_ptr,
    output logic             spk_ok,
    output logic             spk_bad,
    output logic [BIN_W-1:0] wr_bin,
    output logic [BIN_W-1:0] rd_bin,
    output logic             hit
);
    logic             served;
    logic [BIN_W-1:0] step;

    // Target slot: served neurons already live one step ahead.
    always_comb begin
        spk_ok  = spike_valid && (spike_delay != '0);
        spk_bad = spike_valid && (spike_delay == '0);
        served  = busy && (spike_nid < rd_idx);
        step    = {{(BIN_W-1){1'b0}}, served};
        wr_bin  = now_ptr + spike_delay + step;
        rd_bin  = now_ptr + 1'b1;
        hit     = busy && spk_ok && (spike_nid == rd_idx) && (wr_bin == rd_bin);
    end
endmodule

// File: rtl/spk_bin_acc.sv
// Top: per-neuron ring of signed stimulus slots. Spikes add into a future slot;
// each sweep hands out and clears the next-step slot of each neuron in turn.
// Assumes one spike per cycle at most and a downstream stage that always accepts.
module spk_bin_acc #(
    parameter int NUM_NEURONS = 4,
    parameter int NUM_BINS    = 16,
    localparam int NID_W      = $clog2(NUM_NEURONS),
    localparam int BIN_W      = $clog2(NUM_BINS),
    localparam int SW         = spk_bin_pkg::STIM_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spike_valid,
    input  logic [NID_W-1:0]     spike_nid,
    input  logic [BIN_W-1:0]     spike_delay,
    input  logic [SW-1:0]        spike_weight,
    input  logic                 tick,
    output logic                 busy,
    output logic                 stim_valid,
    output logic [NID_W-1:0]     stim_nid,
    output logic [SW-1:0]        stim_out,
    output logic                 delay_err
);
    import spk_bin_pkg::*;

    logic signed [SW-1:0] slots [NUM_NEURONS][NUM_BINS];
    logic [NID_W-1:0]     rd_idx;
    logic [BIN_W-1:0]     now_ptr;
    logic [BIN_W-1:0]     wr_bin;
    logic [BIN_W-1:0]     rd_bin;
    logic                 spk_ok;
    logic                 spk_bad;
    logic                 hit;
    logic signed [SW-1:0] rd_val;
    logic signed [SW-1:0] rd_sum;
    logic signed [SW-1:0] wr_val;

    spk_bin_sweep #(.NUM_NEURONS(NUM_NEURONS), .NUM_BINS(NUM_BINS)) u_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .busy    (busy),
        .rd_idx  (rd_idx),
        .now_ptr (now_ptr)
    );

    spk_bin_addr #(.NUM_NEURONS(NUM_NEURONS), .NUM_BINS(NUM_BINS)) u_addr (
        .spike_valid (spike_valid),
        .spike_nid   (spike_nid),
        .spike_delay (spike_delay),
        .busy        (busy),
        .rd_idx      (rd_idx),
        .now_ptr     (now_ptr),
        .spk_ok      (spk_ok),
        .spk_bad     (spk_bad),
        .wr_bin      (wr_bin),
        .rd_bin      (rd_bin),
        .hit         (hit)
    );

    // Read value, folded spike and the updated write value.
    always_comb begin
        rd_val = slots[rd_idx][rd_bin];
        rd_sum = hit ? sat_add(rd_val, $signed(spike_weight)) : rd_val;
        wr_val = sat_add(slots[spike_nid][wr_bin], $signed(spike_weight));
    end

    // Slot storage: spike accumulation and read-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_NEURONS; n++)
                for (int b = 0; b < NUM_BINS; b++)
                    slots[n][b] <= '0;
        end else begin
            if (spk_ok && !hit)
                slots[spike_nid][wr_bin] <= wr_val;
            if (busy)
                slots[rd_idx][rd_bin] <= '0;
        end
    end

    // Registered outputs toward the update stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stim_valid <= 1'b0;
            stim_nid   <= '0;
            stim_out   <= '0;
            delay_err  <= 1'b0;
        end else begin
            stim_valid <= busy;
            stim_nid   <= rd_idx;
            stim_out   <= busy ? rd_sum : '0;
            delay_err  <= spk_bad;
        end
    end
endmodule

// File: rtl/spk_bin_acc_chk.sv
// Protocol checker for the spike slot accumulator, bound to the top module.
module spk_bin_acc_chk #(
    parameter int NUM_NEURONS = 4,
    parameter int NUM_BINS    = 16,
    localparam int NID_W      = $clog2(NUM_NEURONS),
    localparam int BIN_W      = $clog2(NUM_BINS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             spike_valid,
    input logic [BIN_W-1:0] spike_delay,
    input logic             busy,
    input logic             stim_valid,
    input logic [NID_W-1:0] stim_nid,
    input logic             delay_err
);
    localparam logic [NID_W-1:0] LAST_IDX = NID_W'(NUM_NEURONS - 1);
    int unsigned busy_cnt;

    // Length of the current busy window.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cnt <= 0;
        else                 busy_cnt <= busy_cnt + 1;
    end

    AST_ZERO_DELAY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (spike_valid && spike_delay == '0) |=> delay_err); // R8
    AST_LEGAL_NOT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        !(spike_valid && spike_delay == '0) |=> !delay_err); // R8
    AST_VALID_TRAILS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> stim_valid); // R5
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !stim_valid); // R5
    AST_FIRST_NEURON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stim_valid) |-> stim_nid == '0); // R5
    AST_NEURON_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stim_valid && stim_nid != LAST_IDX) |=> (stim_valid && stim_nid == $past(stim_nid) + 1'b1)); // R5
    AST_SWEEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_cnt < NUM_NEURONS); // R6
endmodule

bind spk_bin_acc spk_bin_acc_chk #(.NUM_NEURONS(NUM_NEURONS), .NUM_BINS(NUM_BINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spike_valid (spike_valid),
    .spike_delay (spike_delay),
    .busy        (busy),
    .stim_valid  (stim_valid),
    .stim_nid    (stim_nid),
    .delay_err   (delay_err)
);

// File: tb/spk_bin_acc_tb.sv
// Bench for the spike slot accumulator: a behavioural model keeping absolute
// time per neuron is compared on every clock, plus directed scenario checks.
module spk_bin_acc_tb_top;
    localparam int NN = 4;
    localparam int NB = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spike_valid = 1'b0;
    logic [1:0]  spike_nid = '0;
    logic [3:0]  spike_delay = '0;
    logic [15:0] spike_weight = '0;
    logic        tick = 1'b0;
    logic        busy;
    logic        stim_valid;
    logic [1:0]  stim_nid;
    logic [15:0] stim_out;
    logic        delay_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    spk_bin_acc #(.NUM_NEURONS(NN), .NUM_BINS(NB)) dut_i (
        .clk (clk), .rst_n (rst_n), .spike_valid (spike_valid), .spike_nid (spike_nid),
        .spike_delay (spike_delay), .spike_weight (spike_weight), .tick (tick),
        .busy (busy), .stim_valid (stim_valid), .stim_nid (stim_nid),
        .stim_out (stim_out), .delay_err (delay_err)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clamp(int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Reference model: absolute time per neuron, slots keyed by absolute time.
    int  acc [NN][int];
    int  tn [NN];
    bit  m_busy;
    int  m_idx;
    bit  e_valid;
    int  e_nid;
    int  e_out;
    bit  e_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NN; n++) begin acc[n].delete(); tn[n] = 0; end
            m_busy = 0; m_idx = 0; e_valid = 0; e_err = 0; e_nid = 0; e_out = 0;
        end else begin
            e_valid = 0;
            e_err   = spike_valid && spike_delay == 0;
            if (spike_valid && spike_delay != 0) begin
                int n;
                int k;
                n = spike_nid;
                k = tn[n] + int'(spike_delay);
                acc[n][k] = clamp((acc[n].exists(k) ? acc[n][k] : 0) + int'($signed(spike_weight)));
            end
            if (m_busy) begin
                int k;
                k = tn[m_idx] + 1;
                e_out = acc[m_idx].exists(k) ? acc[m_idx][k] : 0;
                acc[m_idx].delete(k);
                tn[m_idx] = k;
                e_valid = 1; e_nid = m_idx;
                m_idx++;
                if (m_idx == NN) m_busy = 0;
            end else if (tick) begin
                m_busy = 1; m_idx = 0;
            end
        end
    end

    // Per-clock comparison and capture, away from the active edge.
    int  last_out [NN];
    int  vcount;
    bit  nz_seen;
    bit  err_seen;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 busy", int'(busy), int'(m_busy));
            chk("R5 stim_valid", int'(stim_valid), int'(e_valid));
            chk("R8 delay_err", int'(delay_err), int'(e_err));
            if (e_valid) begin
                chk("R5 stim_nid", int'(stim_nid), e_nid);
                chk("R2 stim_out", int'($signed(stim_out)), e_out);
            end
            if (stim_valid) begin
                last_out[stim_nid] = int'($signed(stim_out));
                vcount++;
                if (stim_out != 0) nz_seen = 1;
            end
            if (delay_err) err_seen = 1;
        end
    end

    task automatic spike(int n, int d, int w);
        spike_valid  = 1'b1;
        spike_nid    = n[1:0];
        spike_delay  = d[3:0];
        spike_weight = w[15:0];
        @(negedge clk);
        spike_valid  = 1'b0;
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (NN + 2) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 stim_valid after reset", int'(stim_valid), 0);
        chk("R1 delay_err after reset", int'(delay_err), 0);
        @(negedge clk);
        nz_seen = 0;
        do_tick();
        chk("R1 empty slots", int'(nz_seen), 0);

        // R2 and R11: delay placement and negative weight.
        spike(0, 3, 100);
        spike(1, 1, -50);
        do_tick();
        chk("R11 negative weight n1", last_out[1], -50);
        chk("R2 not early n0", last_out[0], 0);
        do_tick();
        chk("R2 not early n0 second", last_out[0], 0);
        do_tick();
        chk("R2 delay 3 lands n0", last_out[0], 100);

        // R3: summation in one slot.
        spike(2, 2, 10);
        spike(2, 2, 20);
        spike(2, 2, 5);
        do_tick();
        do_tick();
        chk("R3 sum n2", last_out[2], 35);

        // R4 and R11: saturation both ways, mixed signs.
        spike(1, 3, 30000);
        spike(1, 3, 30000);
        spike(3, 3, -30000);
        spike(3, 3, -30000);
        spike(0, 3, 100);
        spike(0, 3, -300);
        repeat (3) do_tick();
        chk("R4 positive clamp n1", last_out[1], 32767);
        chk("R4 negative clamp n3", last_out[3], -32768);
        chk("R11 mixed signs n0", last_out[0], -200);

        // R8 and R7: rejected spike, then a full ring of ticks must be empty.
        nz_seen = 0; err_seen = 0;
        spike(1, 0, 500);
        @(negedge clk);
        chk("R8 error pulse", int'(err_seen), 1);
        repeat (NB) do_tick();
        chk("R7 cleared slots and R8 no write", int'(nz_seen), 0);

        // R6: tick held while busy yields one sweep only.
        vcount = 0;
        tick = 1'b1;
        repeat (3) @(negedge clk);
        tick = 1'b0;
        repeat (NN + 3) @(negedge clk);
        chk("R6 one sweep", vcount, NN);
        chk("R6 idle after", int'(busy), 0);

        // R9 and R10: spikes in the cycles of a sweep.
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        spike(0, 1, 7);
        spike(0, 2, 5);
        spike(3, 1, 9);
        repeat (NN) @(negedge clk);
        chk("R9 folded into n0", last_out[0], 7);
        chk("R10 unserved n3 old step", last_out[3], 9);
        do_tick();
        chk("R10 served n0 not early", last_out[0], 0);
        do_tick();
        chk("R10 served n0 new step", last_out[0], 5);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule